// File: doc/BRIEF.md
# Station-Pair Segment Road Matcher

The matcher takes one segment from each of two detector stations every clock and decides whether the two could belong to one track. Each segment has a polar coordinate, an azimuth, a signed bend angle, a quality and a presence flag. The block requires the polar difference to fall inside a window chosen by the first segment's polar value. It also requires the azimuth difference, corrected by each segment's own bend angle, to be accepted by that segment's bend table. When both conditions hold, it grades the size of the azimuth difference against three programmable thresholds. The grade is then capped by the weaker of the two input qualities.

The windows, the two bend tables and the thresholds are held in registers. They are loaded through a single-cycle write port that shares no resource with the data path, so a comparison can be presented in every cycle, including cycles that carry a write. The result is a 2-bit quality in which 0 means "no match". It comes with a valid flag at a fixed latency.

Top module: `road_matcher`

## Requirements
- R1: `out_vld` is 1 after the third rising clock edge counting the edge that captures the inputs, exactly when `a_vld` or `b_vld` was 1 at that capture, and 0 otherwise; a comparison is accepted in every cycle.
- R2: `out_q` is 0 for a comparison in which `a_vld` or `b_vld` was 0.
- R3: With deta = a_eta − b_eta (signed), the polar road passes only when |deta| ≤ polar window entry number `a_eta`; when it fails, `out_q` is 0.
- R4: With dphi = a_phi − b_phi (signed), and |dphi| capped at 127, the azimuth grade is 3 if |dphi| ≤ T0, otherwise 2 if ≤ T1, otherwise 1 if ≤ T2, otherwise 0.
- R5: For each segment, k = dphi − bend (bend is a 7-bit two's-complement value). Its table index is k + 64. A match requires bit 1 at that index in that segment's bend table (table A for segment a, table B for segment b); otherwise `out_q` is 0.
- R6: With m = min(a_q, b_q), the quality cap is 0 for m=0, 1 for m in 1..2, 2 for m in 3..5 and 3 for m in 6..7. When R2, R3 and R5 allow a match, `out_q` = min(azimuth grade, cap).
- R7: k saturates to the range −64..63 before indexing, so an out-of-range difference uses entry 0 or 127 rather than wrapping.
- R8: A write is made by setting `cfg_we`=1 for one cycle. `cfg_addr[8:7]` selects the target: 0 is the polar window (index `cfg_addr[4:0]`, value `cfg_data[5:0]`), 1 is bend table A and 2 is bend table B (index `cfg_addr[6:0]`, bit `cfg_data[0]`), and 3 is threshold T0/T1/T2 (`cfg_addr[1:0]` = 0/1/2, value `cfg_data`). A write in the capture cycle is already seen by that comparison.
- R9: While `rst_n` is 0, `out_vld` and `out_q` are 0 and every table and threshold is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| a_vld | input | 1 | segment a present |
| a_eta | input | 5 | segment a polar coordinate |
| a_phi | input | 8 | segment a azimuth |
| a_bend | input | 7 | segment a bend angle, two's complement |
| a_q | input | 3 | segment a quality |
| b_vld | input | 1 | segment b present |
| b_eta | input | 5 | segment b polar coordinate |
| b_phi | input | 8 | segment b azimuth |
| b_bend | input | 7 | segment b bend angle, two's complement |
| b_q | input | 3 | segment b quality |
| cfg_we | input | 1 | configuration write strobe |
| cfg_addr | input | 9 | configuration address |
| cfg_data | input | 7 | configuration data |
| out_vld | output | 1 | result valid |
| out_q | output | 2 | match quality, 0 = no match |

## Verification
A configuration write and a comparison can fall in the same cycle. The bench provokes this in two ways. In one, the write rewrites the very window, bend entry or threshold that the comparison captured in that cycle uses. In the other, a stream of back-to-back comparisons runs while writes hit other entries. The behavioural reference applies each write before evaluating the comparison captured on the same edge. Every clock it checks that the stream shows neither a gap nor a stale table value.

// File: rtl/road_matcher.sv
module road_matcher #(
  parameter int ETA_W  = 5,
  parameter int PHI_W  = 8,
  parameter int BEND_W = 7,
  parameter int Q_W    = 3,
  parameter int CFG_AW = 9,
  parameter int CFG_DW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_vld,
  input  logic [ETA_W-1:0]  a_eta,
  input  logic [PHI_W-1:0]  a_phi,
  input  logic [BEND_W-1:0] a_bend,
  input  logic [Q_W-1:0]    a_q,
  input  logic              b_vld,
  input  logic [ETA_W-1:0]  b_eta,
  input  logic [PHI_W-1:0]  b_phi,
  input  logic [BEND_W-1:0] b_bend,
  input  logic [Q_W-1:0]    b_q,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  output logic              out_vld,
  output logic [1:0]        out_q
);
  localparam int ETA_N   = 1 << ETA_W;
  localparam int DETA_W  = ETA_W + 1;
  localparam int BIX_W   = BEND_W;
  localparam int BIX_N   = 1 << BIX_W;
  localparam int DPHI_W  = PHI_W + 1;
  localparam int BD_W    = DPHI_W + 1;
  localparam int MAG_MAX = BIX_N - 1;
  localparam int BD_MAX  = BIX_N / 2 - 1;
  localparam int BD_MIN  = -(BIX_N / 2);

  logic [DETA_W-1:0] pwin [ETA_N];
  logic [BIX_N-1:0]  btab_a, btab_b;
  logic [CFG_DW-1:0] thr [3];

  wire [1:0] cfg_rgn = cfg_addr[CFG_AW-1 -: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ETA_N; i++) pwin[i] <= '0;
      btab_a <= '0;
      btab_b <= '0;
      for (int i = 0; i < 3; i++) thr[i] <= '0;
    end else if (cfg_we) begin
      case (cfg_rgn)
        2'd0: pwin[cfg_addr[ETA_W-1:0]] <= cfg_data[DETA_W-1:0];
        2'd1: btab_a[cfg_addr[BIX_W-1:0]] <= cfg_data[0];
        2'd2: btab_b[cfg_addr[BIX_W-1:0]] <= cfg_data[0];
        default: if (cfg_addr[1:0] != 2'd3) thr[cfg_addr[1:0]] <= cfg_data;
      endcase
    end
  end

  function automatic logic [BIX_W-1:0] bend_idx(input logic signed [DPHI_W-1:0] d,
                                                input logic [BEND_W-1:0] b);
    logic signed [BD_W-1:0] x;
    x = $signed({d[DPHI_W-1], d}) - $signed({{(BD_W-BEND_W){b[BEND_W-1]}}, b});
    if (x > BD_MAX)      bend_idx = BIX_W'(BIX_N - 1);
    else if (x < BD_MIN) bend_idx = '0;
    else                 bend_idx = x[BIX_W-1:0] ^ BIX_W'(BIX_N / 2);
  endfunction

  function automatic logic [1:0] q_cap(input logic [Q_W-1:0] qa, input logic [Q_W-1:0] qb);
    logic [Q_W-1:0] m;
    m = (qa < qb) ? qa : qb;
    if (m == 0)      q_cap = 2'd0;
    else if (m <= 2) q_cap = 2'd1;
    else if (m <= 5) q_cap = 2'd2;
    else             q_cap = 2'd3;
  endfunction

  wire signed [DETA_W-1:0] deta = $signed({1'b0, a_eta}) - $signed({1'b0, b_eta});
  wire signed [DPHI_W-1:0] dphi = $signed({1'b0, a_phi}) - $signed({1'b0, b_phi});
  wire [DPHI_W-1:0] dmag = dphi[DPHI_W-1] ? DPHI_W'(-dphi) : DPHI_W'(dphi);
  wire [BIX_W-1:0]  mag_sat = (dmag > DPHI_W'(MAG_MAX)) ? BIX_W'(MAG_MAX) : dmag[BIX_W-1:0];

  logic              s1_any, s1_both;
  logic [DETA_W-1:0] s1_adeta;
  logic [ETA_W-1:0]  s1_eta;
  logic [BIX_W-1:0]  s1_mag, s1_ia, s1_ib;
  logic [1:0]        s1_cap;
  logic              s2_vld;
  logic [1:0]        s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_any <= 1'b0; s1_both <= 1'b0; s1_adeta <= '0; s1_eta <= '0;
      s1_mag <= '0; s1_ia <= '0; s1_ib <= '0; s1_cap <= '0;
    end else begin
      s1_any   <= a_vld | b_vld;
      s1_both  <= a_vld & b_vld;
      s1_adeta <= deta[DETA_W-1] ? DETA_W'(-deta) : DETA_W'(deta);
      s1_eta   <= a_eta;
      s1_mag   <= mag_sat;
      s1_ia    <= bend_idx(dphi, a_bend);
      s1_ib    <= bend_idx(dphi, b_bend);
      s1_cap   <= q_cap(a_q, b_q);
    end
  end

  wire [1:0] grade = ({1'b0, s1_mag} <= {1'b0, thr[0]}) ? 2'd3 :
                     ({1'b0, s1_mag} <= {1'b0, thr[1]}) ? 2'd2 :
                     ({1'b0, s1_mag} <= {1'b0, thr[2]}) ? 2'd1 : 2'd0;
  wire       pass  = s1_both & (s1_adeta <= pwin[s1_eta]) & btab_a[s1_ia] & btab_b[s1_ib];
  wire [1:0] q_res = !pass ? 2'd0 : (grade < s1_cap) ? grade : s1_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld <= 1'b0; s2_q <= '0; out_vld <= 1'b0; out_q <= '0;
    end else begin
      s2_vld <= s1_any; s2_q <= q_res;
      out_vld <= s2_vld; out_q <= s2_q;
    end
  end
endmodule

module road_matcher_chk #(parameter int Q_W = 3) (
  input logic           clk,
  input logic           rst_n,
  input logic           a_vld,
  input logic           b_vld,
  input logic [Q_W-1:0] a_q,
  input logic [Q_W-1:0] b_q,
  input logic           out_vld,
  input logic [1:0]     out_q
);
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1
  lat_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_vld == $past(a_vld | b_vld, 3)));
  // R2
  inval_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 2'd3) && !($past(a_vld, 3) && $past(b_vld, 3))) |-> (out_q == 2'd0));
  // R6
  qcap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 2'd3) && ($past(a_q, 3) == 0 || $past(b_q, 3) == 0)) |-> (out_q == 2'd0));
  // R1
  q_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != 2'd0) |-> out_vld);
  // R9
  rst_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!out_vld && out_q == 2'd0));
endmodule

bind road_matcher road_matcher_chk #(.Q_W(Q_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_vld(a_vld), .b_vld(b_vld), .a_q(a_q), .b_q(b_q),
  .out_vld(out_vld), .out_q(out_q));

// File: tb/road_matcher_tb.sv
module road_matcher_tb;
  logic clk = 0, rst_n = 0;
  logic a_vld = 0, b_vld = 0, cfg_we = 0;
  logic [4:0] a_eta = 0, b_eta = 0;
  logic [7:0] a_phi = 0, b_phi = 0;
  logic [6:0] a_bend = 0, b_bend = 0, cfg_data = 0;
  logic [2:0] a_q = 0, b_q = 0;
  logic [8:0] cfg_addr = 0;
  logic out_vld;
  logic [1:0] out_q;

  always #4 clk = ~clk;

  road_matcher u_dut (.*);

  int checks = 0, fails = 0;
  int m_win [32];
  bit m_ta [128], m_tb [128];
  int m_thr [3];
  int ev [3], eq [3];
  string et [3];
  string tag = "R9";

  function automatic int sx7(input logic [6:0] b);
    return (b >= 64) ? int'(b) - 128 : int'(b);
  endfunction
  function automatic int bidx(input int d, input logic [6:0] b);
    int k;
    k = d - sx7(b);
    if (k > 63) k = 63;
    if (k < -64) k = -64;
    return k + 64;
  endfunction

  function automatic int model_q();
    int de, dp, mg, g, m, cap;
    if (!(a_vld && b_vld)) return 0;
    de = int'(a_eta) - int'(b_eta);
    if (de < 0) de = -de;
    if (de > m_win[a_eta]) return 0;
    dp = int'(a_phi) - int'(b_phi);
    if (!m_ta[bidx(dp, a_bend)] || !m_tb[bidx(dp, b_bend)]) return 0;
    mg = (dp < 0) ? -dp : dp;
    if (mg > 127) mg = 127;
    g = (mg <= m_thr[0]) ? 3 : (mg <= m_thr[1]) ? 2 : (mg <= m_thr[2]) ? 1 : 0;
    m = (a_q < b_q) ? a_q : b_q;
    cap = (m == 0) ? 0 : (m <= 2) ? 1 : (m <= 5) ? 2 : 3;
    return (g < cap) ? g : cap;
  endfunction

  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      foreach (m_win[i]) m_win[i] = 0;
      foreach (m_ta[i]) begin m_ta[i] = 0; m_tb[i] = 0; end
      foreach (m_thr[i]) m_thr[i] = 0;
      for (int i = 0; i < 3; i++) begin ev[i] = 0; eq[i] = 0; et[i] = "R9"; end
    end else begin
      if (cfg_we) begin
        case (cfg_addr[8:7])
          2'd0: m_win[cfg_addr[4:0]] = int'(cfg_data[5:0]);
          2'd1: m_ta[cfg_addr[6:0]] = cfg_data[0];
          2'd2: m_tb[cfg_addr[6:0]] = cfg_data[0];
          default: if (cfg_addr[1:0] != 3) m_thr[cfg_addr[1:0]] = int'(cfg_data);
        endcase
      end
      ev[2] = ev[1]; eq[2] = eq[1]; et[2] = et[1];
      ev[1] = ev[0]; eq[1] = eq[0]; et[1] = et[0];
      ev[0] = (a_vld || b_vld) ? 1 : 0; eq[0] = model_q(); et[0] = tag;
    end
    @(negedge clk);
    checks++;
    if (out_vld !== ev[2][0] || out_q !== eq[2][1:0]) begin
      fails++;
      $display("FAIL %s: vld=%0b q=%0d expected vld=%0d q=%0d", et[2], out_vld, out_q, ev[2], eq[2]);
    end
    cfg_we = 0;
  endtask

  task automatic wr(input int rgn, input int idx, input int val);
    cfg_we = 1; cfg_addr = 9'((rgn << 7) | idx); cfg_data = 7'(val);
    step();
  endtask

  task automatic seg(input bit va, input int ea, input int pa, input int ba, input int qa,
                     input bit vb, input int eb, input int pb, input int bb, input int qb);
    a_vld = va; a_eta = 5'(ea); a_phi = 8'(pa); a_bend = 7'(ba); a_q = 3'(qa);
    b_vld = vb; b_eta = 5'(eb); b_phi = 8'(pb); b_bend = 7'(bb); b_q = 3'(qb);
  endtask

  task automatic idle(); seg(0,0,0,0,0, 0,0,0,0,0); endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R9";
    // R9: reset state, even with segments presented
    seg(1,3,10,0,7, 1,3,10,0,7);
    for (int i = 0; i < 4; i++) step();
    rst_n = 1;
    idle();
    for (int i = 0; i < 3; i++) step();
    // R9: cleared tables give no match right after reset
    seg(1,3,10,0,7, 1,3,10,0,7);
    step();
    idle();
    tag = "R8";
    for (int i = 0; i < 32; i++) wr(0, i, (i % 6) + 1);
    for (int i = 0; i < 128; i++) begin wr(1, i, 1); wr(2, i, 1); end
    wr(3, 0, 4); wr(3, 1, 10); wr(3, 2, 20);
    wr(3, 3, 1);
    tag = "R4";
    // R4: grades at and across each threshold
    foreach (m_thr[i]) begin
      seg(1,5,100,0,7, 1,5,100 + m_thr[i],0,7); step();
      seg(1,5,100,0,7, 1,5,100 - m_thr[i] - 1,0,7); step();
    end
    seg(1,5,200,0,7, 1,5,10,0,7); step();
    tag = "R6";
    // R6: quality cap from the weaker segment
    for (int q = 0; q < 8; q++) begin seg(1,5,50,0,q, 1,5,50,0,7); step(); end
    seg(1,5,50,0,7, 1,5,48,0,2); step();
    tag = "R2";
    seg(0,5,50,0,7, 1,5,50,0,7); step();
    seg(1,5,50,0,7, 0,5,50,0,7); step();
    tag = "R1";
    idle(); step(); step();
    tag = "R3";
    // R3: polar window edge (entry 11 holds 6)
    seg(1,11,60,0,7, 1,5,60,0,7); step();
    seg(1,11,60,0,7, 1,4,60,0,7); step();
    seg(1,11,60,0,7, 1,17,60,0,7); step();
    seg(1,11,60,0,7, 1,18,60,0,7); step();
    tag = "R5";
    // R5: clear one entry per table, then hit it
    wr(1, 64 + 3 - 5, 0);
    seg(1,5,63,5,7, 1,5,60,0,7); step();
    seg(1,5,63,4,7, 1,5,60,0,7); step();
    wr(1, 64 + 3 - 5, 1);
    wr(2, 64 - 2 + 1, 0);
    seg(1,5,60,0,7, 1,5,62,-1,7); step();
    seg(1,5,60,0,7, 1,5,62,0,7); step();
    wr(2, 64 - 2 + 1, 1);
    tag = "R7";
    // R7: saturated indices 127 and 0
    wr(1, 127, 0);
    seg(1,5,250,-60,7, 1,5,5,0,7); step();
    seg(1,5,70,0,7, 1,5,5,0,7); step();
    wr(1, 127, 1);
    wr(2, 0, 0);
    seg(1,5,5,0,7, 1,5,250,60,7); step();
    wr(2, 0, 1);
    seg(1,5,5,0,7, 1,5,250,60,7); step();
    tag = "R8";
    // R8: write in the capture cycle is already seen
    seg(1,9,80,0,7, 1,9,80,0,7);
    wr(1, 64, 0);
    wr(1, 64, 1);
    seg(1,9,80,0,7, 1,2,80,0,7);
    wr(0, 9, 7);
    seg(1,9,80,0,7, 1,9,85,0,7);
    wr(3, 0, 5);
    wr(3, 0, 4);
    // R8/R1: random stream with writes to other entries, no stall
    for (int i = 0; i < 400; i++) begin
      tag = "R1";
      seg($urandom_range(0, 4) != 0, $urandom_range(0,31), $urandom_range(0,255),
          $urandom_range(0,127), $urandom_range(0,7),
          $urandom_range(0, 4) != 0, $urandom_range(0,31), $urandom_range(0,255),
          $urandom_range(0,127), $urandom_range(0,7));
      if (i % 3 == 0) begin
        tag = "R8";
        wr($urandom_range(0,2), $urandom_range(0,127), $urandom_range(0,127));
      end else step();
    end
    idle();
    for (int i = 0; i < 4; i++) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule